// File: doc/BRIEF.md
# Rational Operand Alignment Unit

This block prepares two rational operands for addition. Each operand is kept in a double-mantissa form: a sign, a two's-complement exponent, a fixed (non-repeating) fractional part, and a periodic part that repeats without end. Alongside the digits, each operand carries the length of its fixed part and the length of its periodic part. The fixed length is also the position of the pointer that separates the two parts inside a mantissa register of fixed width.

Digits of equal weight must line up before an adder can combine them. The shift needed depends on the exponents and also on how many fixed digits each operand holds. The block computes a signed displacement equal to the exponent difference minus the fixed-length difference. It selects the operand that has to move and returns that operand's new separator pointer. Moving an operand left never brings in zeros: its periodic digits rotate into the vacated fixed positions. The whole alignment is therefore a pointer update, and no mantissa digit passes through this block. The result is registered one cycle after a valid input.

Top module: `ratAlignTop`

## Requirements
- R1: While reset is active, and in the first cycle after it, validOut, dispNeg, dispMag, moveB, newFix, newPer and ovf are all 0.
- R2: validOut is 1 in the cycle after a cycle with validIn at 1, and 0 in the cycle after a cycle with validIn at 0 (latency of exactly one clock).
- R3: If the fixed length of the moved operand plus dispMag is greater than MANT_W, newFix is MANT_W and ovf is 1. Otherwise ovf is 0.
- R4: With D = (expA - expB) - (fixLenA - fixLenB), where the exponents are two's-complement values and the lengths are unsigned, dispNeg is 1 exactly when D < 0 and dispMag equals |D|. A zero displacement gives dispNeg = 0.
- R5: moveB is 1 (operand B moves) when D < 0. It is 0 (operand A moves, by zero places if D = 0) otherwise. moveB always equals dispNeg.
- R6: When ovf is 0, newFix equals the moved operand's fixed length plus dispMag.
- R7: newPer equals the moved operand's periodic length, unchanged.
- R8: The extreme exponents (+127 against -128 at EXP_W = 8) combined with the maximum length difference give the exact displacement of 287 with no wrap-around, in both directions.
- R9: A cycle with validIn at 0 leaves dispNeg, dispMag, moveB, newFix, newPer and ovf unchanged, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operand fields are valid this cycle |
| expA | input | EXP_W | Exponent of operand A, two's complement |
| expB | input | EXP_W | Exponent of operand B, two's complement |
| fixLenA | input | LEN_W | Fixed-mantissa length of A (0..MANT_W) |
| fixLenB | input | LEN_W | Fixed-mantissa length of B (0..MANT_W) |
| perLenA | input | LEN_W | Periodic-mantissa length of A |
| perLenB | input | LEN_W | Periodic-mantissa length of B |
| validOut | output | 1 | Registered results are valid |
| dispNeg | output | 1 | Displacement is negative |
| dispMag | output | DISP_W | Magnitude of the displacement |
| moveB | output | 1 | 1: operand B moves, 0: operand A moves |
| newFix | output | LEN_W | Updated separator pointer of the moved operand |
| newPer | output | LEN_W | Periodic length of the moved operand |
| ovf | output | 1 | Pointer saturated at MANT_W |

## Verification
The displacement is tested with cases where only the exponents differ, where only the fixed lengths differ, where the two terms cancel to zero, and where both are negative exponents. These cases show whether the length term is subtracted with the correct sign and whether zero picks operand A. The pointer is tested at exactly MANT_W and at one above it, which shows where saturation starts. The two extreme-exponent cases test that the cascaded subtractors and the sign extension are wide enough in each direction. Idle cycles with changed inputs show that the registers hold.

// File: rtl/ratAlignPkg.sv
package ratAlignPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the result registers this cycle
  } ctrl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ratAlignSub.sv
// Subtractor built as complement plus adder. Two sums are formed in
// parallel: a + ~b (difference minus one) and a + ~b + 1 (difference).
// With ABS_OUT set, the sign picks which sum gives the magnitude.
module ratAlignSub #(
  parameter int W       = 8,
  parameter bit ABS_OUT = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,     // difference, or its magnitude when ABS_OUT
  output logic         resNeg   // sign of a - b
);

  logic [W-1:0] bInv;
  logic [W-1:0] sumHi;

  assign bInv   = ~b;
  assign sumHi  = a + bInv + W'(1);
  assign resNeg = sumHi[W-1];

  generate
    if (ABS_OUT) begin : g_abs
      logic [W-1:0] sumLo;
      assign sumLo = a + bInv;
      // negative: |a-b| = -(a-b) = ~(a-b-1)
      assign res = resNeg ? ~sumLo : sumHi;
    end else begin : g_diff
      assign res = sumHi;
    end
  endgenerate

endmodule

// File: rtl/ratAlignCtrl.sv
module ratAlignCtrl
  import ratAlignPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  validIn,
  output ctrl_t ctrl,
  output logic  validOut
);

  always_comb begin
    ctrl         = '0;
    ctrl.capture = validIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/ratAlignDp.sv
module ratAlignDp
  import ratAlignPkg::*;
#(
  parameter int  EXP_W  = 8,
  parameter int  MANT_W = 32,
  localparam int LEN_W  = $clog2(MANT_W + 1),
  localparam int DISP_W = maxOf(EXP_W, LEN_W) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [EXP_W-1:0]  expA,
  input  logic [EXP_W-1:0]  expB,
  input  logic [LEN_W-1:0]  fixLenA,
  input  logic [LEN_W-1:0]  fixLenB,
  input  logic [LEN_W-1:0]  perLenA,
  input  logic [LEN_W-1:0]  perLenB,
  output logic              dispNeg,
  output logic [DISP_W-1:0] dispMag,
  output logic              moveB,
  output logic [LEN_W-1:0]  newFix,
  output logic [LEN_W-1:0]  newPer,
  output logic              ovf
);

  localparam int EW1   = EXP_W + 1;
  localparam int LW1   = LEN_W + 1;
  localparam int PTR_W = DISP_W + 1;

  // Stage 1: exponent difference and fixed-length difference
  logic [EW1-1:0]    expDiff;
  logic              expNeg;
  logic [LW1-1:0]    lenDiff;
  logic              lenNeg;

  ratAlignSub #(.W(EW1), .ABS_OUT(1'b0)) u_expSub (
    .a      ({expA[EXP_W-1], expA}),
    .b      ({expB[EXP_W-1], expB}),
    .res    (expDiff),
    .resNeg (expNeg)
  );

  ratAlignSub #(.W(LW1), .ABS_OUT(1'b0)) u_lenSub (
    .a      ({1'b0, fixLenA}),
    .b      ({1'b0, fixLenB}),
    .res    (lenDiff),
    .resNeg (lenNeg)
  );

  // Sign extension of both differences to the displacement width
  logic [DISP_W-1:0] expDiffExt;
  logic [DISP_W-1:0] lenDiffExt;
  assign expDiffExt = {{(DISP_W-EW1){expNeg}}, expDiff};
  assign lenDiffExt = {{(DISP_W-LW1){lenNeg}}, lenDiff};

  // Stage 2: displacement sign and magnitude
  logic [DISP_W-1:0] dMag;
  logic              dNeg;

  ratAlignSub #(.W(DISP_W), .ABS_OUT(1'b1)) u_dispSub (
    .a      (expDiffExt),
    .b      (lenDiffExt),
    .res    (dMag),
    .resNeg (dNeg)
  );

  // Stage 3: separator pointer of the moved operand, with saturation
  logic [LEN_W-1:0] movedFix;
  logic [LEN_W-1:0] movedPer;
  logic [PTR_W-1:0] ptrSum;
  logic             ptrOvf;
  logic [LEN_W-1:0] ptrSat;

  always_comb begin
    movedFix = dNeg ? fixLenB : fixLenA;
    movedPer = dNeg ? perLenB : perLenA;
    ptrSum   = PTR_W'(movedFix) + PTR_W'(dMag);
    ptrOvf   = (ptrSum > PTR_W'(MANT_W));
    ptrSat   = ptrOvf ? LEN_W'(MANT_W) : ptrSum[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispNeg <= 1'b0;
      dispMag <= '0;
      moveB   <= 1'b0;
      newFix  <= '0;
      newPer  <= '0;
      ovf     <= 1'b0;
    end else if (ctrl.capture) begin
      dispNeg <= dNeg;
      dispMag <= dMag;
      moveB   <= dNeg;
      newFix  <= ptrSat;
      newPer  <= movedPer;
      ovf     <= ptrOvf;
    end
  end

endmodule

// File: rtl/ratAlignTop.sv
module ratAlignTop
  import ratAlignPkg::*;
#(
  parameter int  EXP_W  = 8,
  parameter int  MANT_W = 32,
  localparam int LEN_W  = $clog2(MANT_W + 1),
  localparam int DISP_W = maxOf(EXP_W, LEN_W) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [EXP_W-1:0]  expA,
  input  logic [EXP_W-1:0]  expB,
  input  logic [LEN_W-1:0]  fixLenA,
  input  logic [LEN_W-1:0]  fixLenB,
  input  logic [LEN_W-1:0]  perLenA,
  input  logic [LEN_W-1:0]  perLenB,
  output logic              validOut,
  output logic              dispNeg,
  output logic [DISP_W-1:0] dispMag,
  output logic              moveB,
  output logic [LEN_W-1:0]  newFix,
  output logic [LEN_W-1:0]  newPer,
  output logic              ovf
);

  ctrl_t ctrl;

  ratAlignCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .ctrl     (ctrl),
    .validOut (validOut)
  );

  ratAlignDp #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .expA    (expA),
    .expB    (expB),
    .fixLenA (fixLenA),
    .fixLenB (fixLenB),
    .perLenA (perLenA),
    .perLenB (perLenB),
    .dispNeg (dispNeg),
    .dispMag (dispMag),
    .moveB   (moveB),
    .newFix  (newFix),
    .newPer  (newPer),
    .ovf     (ovf)
  );

endmodule

// File: rtl/ratAlignChk.sv
module ratAlignChk #(
  parameter int MANT_W = 32,
  parameter int LEN_W  = 6,
  parameter int DISP_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [LEN_W-1:0]  fixLenA,
  input logic [LEN_W-1:0]  fixLenB,
  input logic [LEN_W-1:0]  perLenA,
  input logic [LEN_W-1:0]  perLenB,
  input logic              validOut,
  input logic              dispNeg,
  input logic [DISP_W-1:0] dispMag,
  input logic              moveB,
  input logic [LEN_W-1:0]  newFix,
  input logic [LEN_W-1:0]  newPer,
  input logic              ovf
);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  assert_ptr_saturate_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (32'(newFix) == MANT_W));

  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    32'(newFix) <= MANT_W);

  assert_zero_positive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dispMag == '0) |-> !dispNeg);

  assert_move_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
    moveB == dispNeg);

  assert_ptr_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !ovf) |->
      (32'(newFix) == 32'(moveB ? $past(fixLenB) : $past(fixLenA)) + 32'(dispMag)));

  assert_per_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (newPer == (moveB ? $past(perLenB) : $past(perLenA))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(dispMag) && $stable(newFix) && $stable(newPer) &&
                  $stable(ovf) && $stable(moveB)));

endmodule

bind ratAlignTop ratAlignChk #(
  .MANT_W (MANT_W),
  .LEN_W  (LEN_W),
  .DISP_W (DISP_W)
) u_ratAlignChk (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .fixLenA  (fixLenA),
  .fixLenB  (fixLenB),
  .perLenA  (perLenA),
  .perLenB  (perLenB),
  .validOut (validOut),
  .dispNeg  (dispNeg),
  .dispMag  (dispMag),
  .moveB    (moveB),
  .newFix   (newFix),
  .newPer   (newPer),
  .ovf      (ovf)
);

// File: tb/test_ratAlignTop.sv
`timescale 1ns/1ps
module test_ratAlignTop;

  localparam int EXP_W  = 8;
  localparam int MANT_W = 32;
  localparam int LEN_W  = 6;
  localparam int DISP_W = 10;

  typedef struct packed {
    logic [EXP_W-1:0]  ea;
    logic [EXP_W-1:0]  eb;
    logic [LEN_W-1:0]  fa;
    logic [LEN_W-1:0]  fb;
    logic [LEN_W-1:0]  pa;
    logic [LEN_W-1:0]  pb;
    logic              neg;
    logic [DISP_W-1:0] mag;
    logic              mvB;
    logic [LEN_W-1:0]  nfix;
    logic [LEN_W-1:0]  nper;
    logic              ov;
  } vec_t;

  localparam int NV = 10;
  // ea, eb, fa, fb, pa, pb | neg, mag, moveB, newFix, newPer, ovf
  localparam vec_t VECS [NV] = '{
    '{8'd5,   8'd3,   6'd4,  6'd6,  6'd3, 6'd2, 1'b0, 10'd4,   1'b0, 6'd8,  6'd3, 1'b0}, // exp and len both push A
    '{8'd2,   8'd7,   6'd3,  6'd1,  6'd5, 6'd4, 1'b1, 10'd7,   1'b1, 6'd8,  6'd4, 1'b0}, // B moves
    '{8'd4,   8'd6,   6'd8,  6'd10, 6'd6, 6'd3, 1'b0, 10'd0,   1'b0, 6'd8,  6'd6, 1'b0}, // terms cancel
    '{8'hFD,  8'hF6,  6'd0,  6'd5,  6'd7, 6'd1, 1'b0, 10'd12,  1'b0, 6'd12, 6'd7, 1'b0}, // -3 vs -10
    '{8'd30,  8'd0,   6'd2,  6'd2,  6'd5, 6'd9, 1'b0, 10'd30,  1'b0, 6'd32, 6'd5, 1'b0}, // exactly MANT_W
    '{8'd31,  8'd0,   6'd2,  6'd2,  6'd4, 6'd1, 1'b0, 10'd31,  1'b0, 6'd32, 6'd4, 1'b1}, // one above
    '{8'h7F,  8'h80,  6'd0,  6'd32, 6'd1, 6'd6, 1'b0, 10'd287, 1'b0, 6'd32, 6'd1, 1'b1}, // +extreme
    '{8'h80,  8'h7F,  6'd32, 6'd0,  6'd3, 6'd2, 1'b1, 10'd287, 1'b1, 6'd32, 6'd2, 1'b1}, // -extreme
    '{8'd0,   8'd0,   6'd0,  6'd20, 6'd1, 6'd6, 1'b0, 10'd20,  1'b0, 6'd20, 6'd1, 1'b0}, // length only, A
    '{8'd0,   8'd0,   6'd9,  6'd0,  6'd2, 6'd8, 1'b1, 10'd9,   1'b1, 6'd9,  6'd8, 1'b0}  // length only, B
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              validIn = 1'b0;
  logic [EXP_W-1:0]  expA = '0, expB = '0;
  logic [LEN_W-1:0]  fixLenA = '0, fixLenB = '0, perLenA = '0, perLenB = '0;
  logic              validOut, dispNeg, moveB, ovf;
  logic [DISP_W-1:0] dispMag;
  logic [LEN_W-1:0]  newFix, newPer;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ratAlignTop #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_ratAlignTop (
    .clk(clk), .rstN(rstN), .validIn(validIn),
    .expA(expA), .expB(expB), .fixLenA(fixLenA), .fixLenB(fixLenB),
    .perLenA(perLenA), .perLenB(perLenB),
    .validOut(validOut), .dispNeg(dispNeg), .dispMag(dispMag), .moveB(moveB),
    .newFix(newFix), .newPer(newPer), .ovf(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkOuts(input string tag, input vec_t v);
    check({tag, " R4 dispNeg"}, int'(dispNeg), int'(v.neg));
    check({tag, " R4 R8 dispMag"}, int'(dispMag), int'(v.mag));
    check({tag, " R5 moveB"}, int'(moveB), int'(v.mvB));
    check({tag, " R3 R6 newFix"}, int'(newFix), int'(v.nfix));
    check({tag, " R7 newPer"}, int'(newPer), int'(v.nper));
    check({tag, " R3 ovf"}, int'(ovf), int'(v.ov));
  endtask

  task automatic checkZero(input string tag);
    check({tag, " R1 validOut"}, int'(validOut), 0);
    check({tag, " R1 dispNeg"}, int'(dispNeg), 0);
    check({tag, " R1 dispMag"}, int'(dispMag), 0);
    check({tag, " R1 moveB"}, int'(moveB), 0);
    check({tag, " R1 newFix"}, int'(newFix), 0);
    check({tag, " R1 newPer"}, int'(newPer), 0);
    check({tag, " R1 ovf"}, int'(ovf), 0);
  endtask

  task automatic drive(input vec_t v, input logic vld);
    expA = v.ea; expB = v.eb;
    fixLenA = v.fa; fixLenB = v.fb;
    perLenA = v.pa; perLenB = v.pb;
    validIn = vld;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkZero("in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkZero("after reset");

    // Table walk, back-to-back valid inputs
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      check($sformatf("vec%0d R2 validOut", i), int'(validOut), 1);
      checkOuts($sformatf("vec%0d", i), VECS[i]);
    end

    // R9: idle cycle with different operands must leave results alone
    drive(VECS[0], 1'b0);
    @(negedge clk);
    check("idle R2 validOut", int'(validOut), 0);
    checkOuts("idle R9", VECS[NV-1]);
    drive(VECS[6], 1'b0);
    @(negedge clk);
    checkOuts("idle2 R9", VECS[NV-1]);

    // R2: single valid pulse after idle
    drive(VECS[1], 1'b1);
    @(negedge clk);
    check("pulse R2 validOut", int'(validOut), 1);
    checkOuts("pulse", VECS[1]);
    validIn = 1'b0;
    @(negedge clk);
    check("pulse end R2 validOut", int'(validOut), 0);

    // R1: reset in mid-run clears registered results
    drive(VECS[7], 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    validIn = 1'b0;
    @(negedge clk);
    checkZero("mid reset");
    rstN = 1'b1;
    @(negedge clk);
    checkZero("mid reset release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule